// File: doc/BRIEF.md
# Sampling converter serial port model

This block models the digital side of a 12-bit sampling converter with a three-wire serial port. A fast system clock samples the serial clock and the convert-start input; rising edges are detected internally, so the whole model sits in one clock domain. A rising edge on the convert input captures a parallel test sample and starts a conversion. The serial clock then steps the conversion along. The frame on the data output is a reference-ready flag followed by the 12 sample bits, most significant bit first. The data output has a separate drive enable, so the line can be modelled as high impedance.

Further convert edges are locked out while a conversion runs. A burst of convert edges with no serial clock between them puts the model into a sleep state, and any serial clock edge wakes it. After a wake, an internal settle counter holds the reference-ready flag low for a programmable number of system clocks. The flag also needs an external reference-good input to be high.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `dout_oe` is 0 and `mode_o` is 0 (active, idle). The settle counter starts out expired.
- R2: A convert rising edge, when no conversion is running and the block is not asleep, captures `sample_i`. It sets `dout_oe` to 1, `dout` to 0 and `mode_o` to 1 (converting).
- R3: The second serial clock rising edge after the start drives the reference-ready flag onto `dout`. The flag is 1 only when `ref_ok_i` is 1 and the settle counter has expired.
- R4: Serial clock edges 3 to 14 after the start drive the captured sample onto `dout`, bit 11 first and bit 0 last. Together with R3 this gives a 13-bit frame.
- R5: Convert rising edges that arrive before the 14th serial clock edge of a conversion are ignored. The captured sample and the frame position do not change.
- R6: After the 14th serial clock edge, `mode_o` returns to 0. The 15th edge sets `dout_oe` to 0.
- R7: `dout`, `dout_oe` and `mode_o` change only in a cycle that has a serial clock or convert rising edge.
- R8: Four convert rising edges with no serial clock rising edge between them set `mode_o` to 2 (sleep) and `dout_oe` to 0. This count includes ignored edges. Convert edges in sleep have no effect.
- R9: Any serial clock rising edge clears the count of convert-only edges.
- R10: A serial clock rising edge in sleep sets `mode_o` to 0 and does not start a conversion.
- R11: A wake from sleep restarts the settle counter. For SETTLE_CYC system clocks after the wake, the reference-ready flag reads 0. After that it follows `ref_ok_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, sampled by clk |
| conv | input | 1 | Convert start, sampled by clk |
| sample_i | input | 12 | Parallel test sample captured at conversion start |
| ref_ok_i | input | 1 | External reference-good flag |
| dout | output | 1 | Serial data |
| dout_oe | output | 1 | Drive enable for dout (0 = high impedance) |
| mode_o | output | 2 | 0 active, 1 converting, 2 sleep |

## Verification
The hardest states to reach are the ones that depend on how convert edges are counted against serial clock edges. These are the sleep entry after a conversion has already been started by the first of the four edges, and the near miss where one serial clock edge falls between the third and fourth edge. The bench reaches them with directed pulse sequences. It also fires a convert edge in the middle of a frame after changing the sample input, then checks that the original sample still comes out. After a wake it runs a frame at once to read the held-low reference flag, then repeats the frame once the settle window has passed.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_CONV   = 2'd1,
        MODE_SLEEP  = 2'd2
    } mode_e;
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
    parameter int SETTLE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic settled_o
);
    localparam int TW = $clog2(SETTLE_CYC + 1);
    localparam logic [TW-1:0] LOAD = TW'(SETTLE_CYC);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)                cnt_d = LOAD;
        else if (cnt_q != '0)       cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign settled_o = (cnt_q == '0);
endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
    import adc_port_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SLEEP_EDGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              conv_rise,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              ref_ready_i,
    output logic              dout,
    output logic              dout_oe,
    output mode_e             mode,
    output logic              wake_o
);
    localparam int CW   = $clog2(DATA_W + 4);
    localparam int SW   = (SLEEP_EDGES > 2) ? $clog2(SLEEP_EDGES) : 1;
    localparam logic [CW-1:0] IDX_REF  = CW'(1);
    localparam logic [CW-1:0] IDX_LAST = CW'(DATA_W + 1);
    localparam logic [CW-1:0] IDX_LOCK = CW'(DATA_W + 2);
    localparam logic [SW-1:0] SLP_LIM  = SW'(SLEEP_EDGES - 1);

    typedef struct packed {
        logic              asleep;
        logic              busy;
        logic              frame;
        logic              oe;
        logic              dout;
        logic [CW-1:0]     cnt;
        logic [SW-1:0]     conv_only;
        logic [DATA_W-1:0] shift;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wake_o = 1'b0;
        if (st_q.asleep) begin
            if (sck_rise) begin
                st_d.asleep    = 1'b0;
                st_d.conv_only = '0;
                wake_o         = 1'b1;
            end
        end else begin
            if (sck_rise) begin
                st_d.conv_only = '0;
                if (st_q.frame) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == IDX_REF) begin
                        st_d.dout = ref_ready_i;
                    end else if (st_q.cnt > IDX_REF && st_q.cnt <= IDX_LAST) begin
                        st_d.dout  = st_q.shift[DATA_W-1];
                        st_d.shift = {st_q.shift[DATA_W-2:0], 1'b0};
                    end else if (st_q.cnt == IDX_LOCK) begin
                        st_d.frame = 1'b0;
                        st_d.oe    = 1'b0;
                    end
                    if (st_d.cnt == IDX_LOCK) st_d.busy = 1'b0;
                end
            end
            if (conv_rise) begin
                if (st_d.conv_only == SLP_LIM) begin
                    st_d.asleep    = 1'b1;
                    st_d.busy      = 1'b0;
                    st_d.frame     = 1'b0;
                    st_d.oe        = 1'b0;
                    st_d.conv_only = '0;
                end else begin
                    st_d.conv_only = st_d.conv_only + 1'b1;
                    if (!st_q.busy) begin
                        st_d.busy  = 1'b1;
                        st_d.frame = 1'b1;
                        st_d.oe    = 1'b1;
                        st_d.dout  = 1'b0;
                        st_d.cnt   = '0;
                        st_d.shift = sample_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.dout;
    assign dout_oe = st_q.oe;
    assign mode    = st_q.asleep ? MODE_SLEEP : (st_q.busy ? MODE_CONV : MODE_ACTIVE);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SLEEP_EDGES = 4,
    parameter int SETTLE_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              conv,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              ref_ok_i,
    output logic              dout,
    output logic              dout_oe,
    output logic [1:0]        mode_o
);
    logic  sck_rise, conv_rise, wake, settled;
    mode_e mode;

    adc_edge_det u_sck_edge  (.clk(clk), .rst_n(rst_n), .sig_i(sck),  .rise_o(sck_rise));
    adc_edge_det u_conv_edge (.clk(clk), .rst_n(rst_n), .sig_i(conv), .rise_o(conv_rise));

    adc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .start_i(wake), .settled_o(settled)
    );

    adc_frame_engine #(.DATA_W(DATA_W), .SLEEP_EDGES(SLEEP_EDGES)) u_engine (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .conv_rise(conv_rise),
        .sample_i(sample_i), .ref_ready_i(ref_ok_i & settled),
        .dout(dout), .dout_oe(dout_oe), .mode(mode), .wake_o(wake)
    );

    assign mode_o = mode;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sck_rise,
    input logic       conv_rise,
    input logic       dout,
    input logic       dout_oe,
    input logic [1:0] mode_o
);
    // R2: the driver turns on only as a result of a convert edge
    a_r2_oe_from_conv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(conv_rise));

    // R5: a convert edge during a conversion leaves the data line alone
    a_r5_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && conv_rise && !sck_rise) |=> $stable(dout));

    // R7: outputs hold between edges
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_rise && !conv_rise) |=> ($stable(dout) && $stable(dout_oe) && $stable(mode_o)));

    // R8: no drive while asleep
    a_r8_sleep_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> !dout_oe);

    // R10: a serial clock edge wakes the block
    a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && sck_rise) |=> (mode_o == 2'd0 && !dout_oe));
endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .conv_rise(conv_rise),
    .dout(dout), .dout_oe(dout_oe), .mode_o(mode_o)
);

// File: tb/adc_serial_port_tb.sv
`timescale 1ns/1ps
module adc_serial_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        conv = 1'b0;
    logic [11:0] sample = '0;
    logic        ref_ok = 1'b1;
    logic        dout, dout_oe;
    logic [1:0]  mode_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    adc_serial_port #(.DATA_W(12), .SLEEP_EDGES(4), .SETTLE_CYC(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .conv(conv), .sample_i(sample),
        .ref_ok_i(ref_ok), .dout(dout), .dout_oe(dout_oe), .mode_o(mode_o)
    );

    // {sample, ref_ok, expected 13-bit frame}
    localparam logic [25:0] VECS [5] = '{
        {12'hA5C, 1'b1, 13'h1A5C},
        {12'hFFF, 1'b0, 13'h0FFF},
        {12'h001, 1'b1, 13'h1001},
        {12'h800, 1'b1, 13'h1800},
        {12'h000, 1'b0, 13'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic conv_pulse();
        @(posedge clk); #1 conv = 1'b1;
        repeat (3) @(posedge clk);
        #1 conv = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic sck_pulse();
        @(posedge clk); #1 sck = 1'b1;
        repeat (3) @(posedge clk);
        #1 sck = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    // issues edges 1..14 after a start and collects the frame
    task automatic take_frame(output logic [12:0] got, input int mid_conv_edge, input logic [11:0] mid_sample);
        got = '0;
        for (int k = 1; k <= 14; k++) begin
            sck_pulse();
            if (k >= 2) got[14-k] = dout;
            if (k == mid_conv_edge) begin
                sample = mid_sample;
                conv_pulse();
            end
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [12:0] got;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 oe after reset", dout_oe, 0);
        chk("R1 mode after reset", mode_o, 0);

        foreach (VECS[i]) begin
            sample = VECS[i][25:14];
            ref_ok = VECS[i][13];
            conv_pulse();
            chk("R2 oe at start", dout_oe, 1);
            chk("R2 dout at start", dout, 0);
            chk("R2 mode at start", mode_o, 1);
            take_frame(got, 0, '0);
            chk("R3 R4 frame", got, VECS[i][12:0]);
            chk("R6 mode after edge 14", mode_o, 0);
            chk("R6 oe held after edge 14", dout_oe, 1);
            sck_pulse();
            chk("R6 oe after edge 15", dout_oe, 0);
        end

        // R7: nothing moves without edges
        ref_ok = 1'b1;
        sample = 12'h3C3;
        conv_pulse();
        repeat (20) @(posedge clk);
        #1;
        chk("R7 oe idle", dout_oe, 1);
        chk("R7 dout idle", dout, 0);
        chk("R7 mode idle", mode_o, 1);
        // R5: convert edge mid-frame with a new sample is ignored
        take_frame(got, 5, 12'h5A5);
        chk("R5 frame kept", got, 13'h13C3);
        chk("R5 mode after frame", mode_o, 0);
        sck_pulse();

        // R9: sck between third and fourth convert edge prevents sleep
        conv_pulse(); conv_pulse(); conv_pulse();
        sck_pulse();
        conv_pulse();
        chk("R9 no sleep", mode_o, 1);
        for (int k = 0; k < 14; k++) sck_pulse();
        chk("R9 drained", dout_oe, 0);

        // R8: four convert edges, no sck -> sleep
        conv_pulse();
        chk("R8 first edge starts", mode_o, 1);
        conv_pulse(); conv_pulse(); conv_pulse();
        chk("R8 mode sleep", mode_o, 2);
        chk("R8 oe in sleep", dout_oe, 0);
        conv_pulse();
        chk("R8 conv in sleep mode", mode_o, 2);
        chk("R8 conv in sleep oe", dout_oe, 0);

        // R10: wake
        sck_pulse();
        chk("R10 mode after wake", mode_o, 0);
        chk("R10 no drive after wake", dout_oe, 0);

        // R11: reference flag held low right after wake
        sample = 12'hFFF;
        conv_pulse();
        take_frame(got, 0, '0);
        chk("R11 flag held low", got, 13'h0FFF);
        sck_pulse();
        repeat (80) @(posedge clk);
        #1;
        conv_pulse();
        take_frame(got, 0, '0);
        chk("R11 flag after settle", got, 13'h1FFF);
        sck_pulse();

        finish_up();
    end
endmodule